// File: doc/BRIEF.md
# Cascadable Serial Configuration Streamer

This block is the controller of a serial configuration memory. It sends a stored bitstream into an SRAM-based programmable device, one bit for each serial clock. Several of these memories can be chained. After power-on, each instance decides its role from its active-low chip select at the moment the shared open-drain OE line is released. A low chip select means the instance is the master: it generates the serial clock and sends its image first. A high chip select means the instance is a slave: it waits with its data pin in high impedance and shifts on the clock it receives. When an instance has sent its last bit, it releases the data pin and pulls its cascade output low, which enables the next device in the chain.

The master keeps clocking while the downstream devices send `TAIL_BITS` more bits. It then keeps clocking for a window of `DONE_WIN` serial periods while it waits for the target's done flag, which arrives on its chip select. If the flag arrives, the master enters idle. If the flag rises before the data is complete, or never rises within the window, the block pulls OE low to report a failure. With `AUTO_RESTART` set, it releases OE again after `ERR_HOLD` cycles and starts over.

The FSM has these states: `ST_POR`, `ST_HOLD`, `ST_STANDBY`, `ST_SEND`, `ST_CASCADE`, `ST_WINDOW`, `ST_IDLE` and `ST_ERROR`. Its transitions are:
- power-on delay done: `ST_POR` to `ST_HOLD`
- OE released with select low: `ST_HOLD` to `ST_SEND`
- OE released with select high: `ST_HOLD` to `ST_STANDBY`
- select falls: `ST_STANDBY` to `ST_SEND`
- last bit sent: `ST_SEND` to `ST_CASCADE`, or to `ST_WINDOW` for a master with no tail
- tail clocked: `ST_CASCADE` to `ST_WINDOW`
- done seen: `ST_WINDOW` to `ST_IDLE`
- early select high: `ST_SEND` or master `ST_CASCADE` to `ST_ERROR`
- window expired: `ST_WINDOW` to `ST_ERROR`
- hold time done with restart enabled: `ST_ERROR` to `ST_HOLD`
- OE seen low: any other state to `ST_HOLD`

Top module: `cfg_stream_ctrl`

## Requirements
- R1: When the wired OE line is low, the block enters the hold state within one clock. The address counter returns to bit 0, `data_oe` is 0 and `ncasc_out` is 1, whatever the level of `ncs_in`.
- R2: From reset, `oe_pull_low` stays 1 for exactly `POR_CYC` clock cycles and then drops. While in reset, `data_oe`=0, `dclk_oe`=0 and `ncasc_out`=1.
- R3: When OE is released, `ncs_in` is sampled. High selects slave: `dclk_oe`=0 and `data_oe`=0, and edges on `dclk_in` are ignored until `ncs_in` goes low. After that the slave sends one bit per rising edge of `dclk_in`, starting from bit 0. Low selects master, which drives `dclk_out` with `dclk_oe`=1.
- R4: Bit k of the image is bit (k mod `WORD_W`) of memory word k / `WORD_W`, so each word is sent least-significant bit first. The read port returns a word one clock after its address. Each bit is stable on `data_out` with `data_oe`=1 at the rising edge of the serial clock that carries it. Exactly `IMAGE_BITS` bits are sent.
- R5: After its last bit, the block drops `data_oe` and drives `ncasc_out` low.
- R6: After handoff, the master keeps generating one serial clock per `DCLK_DIV` cycles, for `TAIL_BITS` periods and then through the done window.
- R7: If `ncs_in` is high while bits are still being sent, `oe_pull_low` is 1 in the next cycle.
- R8: If `ncs_in` stays low for the `DONE_WIN` window periods that follow the tail, `oe_pull_low` rises at the end of the last window period. That is exactly `TAIL_BITS`+`DONE_WIN` serial clock rises after `ncasc_out` falls.
- R9: If `ncs_in` goes high during the window, the master goes idle. In idle `dclk_out`=0 with `dclk_oe`=1, and `data_out`=1 with `data_oe`=`IDLE_DRIVE`. The block does not report an error.
- R10: With `AUTO_RESTART`=1, after an error `oe_pull_low` stays 1 for exactly `ERR_HOLD` cycles. The block then resamples its role and sends again from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Active-low power-on reset |
| oe_in | input | 1 | Sampled level of the wired OE line |
| oe_pull_low | output | 1 | When 1, pulls the OE line low |
| ncs_in | input | 1 | Active-low chip select (done flag or previous cascade) |
| dclk_in | input | 1 | Serial clock pin, sampled in slave role |
| dclk_out | output | 1 | Serial clock driven in master role |
| dclk_oe | output | 1 | Drive enable for the serial clock pin |
| data_out | output | 1 | Serial data value |
| data_oe | output | 1 | Drive enable for the serial data pin |
| ncasc_out | output | 1 | Active-low cascade enable to the next device |
| mem_addr | output | AW | Word address of the image memory |
| mem_rdata | input | WORD_W | Word read, one clock after its address |

## Verification
The checker tests on every clock the properties that can be seen in a single cycle:
- the data pin is released while OE stays low or after handoff;
- a standby slave drives no pin;
- an early select rise leads to OE being pulled;
- a done flag in the window leads to idle;
- idle drives its fixed levels.

Only the bench scenarios can show the properties that count over a long run: the exact bit order across words, the number of clock rises between handoff and a window timeout, the lengths of the power-on and error pulses, and the restart from bit 0. The bench acts as target, as upstream device and as memory.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    typedef enum logic [3:0] {
        ST_POR,
        ST_HOLD,
        ST_STANDBY,
        ST_SEND,
        ST_CASCADE,
        ST_WINDOW,
        ST_IDLE,
        ST_ERROR
    } cfg_state_e;

endpackage

// File: rtl/cfg_clk_gen.sv
// Serial clock generator for the master role: one period every DIV cycles.
module cfg_clk_gen #(
    parameter int DIV = 8,
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic dclk,
    output logic period_end
);

    logic [PW-1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (!run || ph == PW'(DIV - 1)) begin
            ph <= '0;
        end else begin
            ph <= ph + PW'(1);
        end
    end

    // Rising edge in mid-period: data has been stable since phase 1.
    assign dclk       = run && (ph >= PW'(DIV / 2));
    assign period_end = run && (ph == PW'(DIV - 1));

endmodule

// File: rtl/cfg_edge_sync.sv
// Synchronises the incoming serial clock and flags its rising edges.
module cfg_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    logic [2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[1:0], pin};
        end
    end

    assign rise = sh[1] && !sh[2];

endmodule

// File: rtl/cfg_bit_counter.sv
// Address counter: bit index split into word address and bit offset.
module cfg_bit_counter #(
    parameter int WORD_W     = 8,
    parameter int IMAGE_BITS = 40,
    localparam int CW     = $clog2(IMAGE_BITS + 1),
    localparam int OFFW   = $clog2(WORD_W),
    localparam int NWORDS = (IMAGE_BITS + WORD_W - 1) / WORD_W,
    localparam int AW     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    output logic [AW-1:0]   mem_addr,
    output logic [OFFW-1:0] off_q,
    output logic            last
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            off_q <= '0;
        end else begin
            if (clear) begin
                cnt <= '0;
            end else if (step) begin
                cnt <= cnt + CW'(1);
            end
            // Offset tracks the one-cycle latency of the read port.
            off_q <= cnt[OFFW-1:0];
        end
    end

    assign mem_addr = AW'(cnt >> OFFW);
    assign last     = (cnt == CW'(IMAGE_BITS - 1));

endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
    import cfg_stream_pkg::*;
#(
    parameter int WORD_W       = 8,
    parameter int IMAGE_BITS   = 40,
    parameter int DCLK_DIV     = 8,
    parameter int TAIL_BITS    = 24,
    parameter int DONE_WIN     = 16,
    parameter int POR_CYC      = 20,
    parameter int ERR_HOLD     = 6,
    parameter bit IDLE_DRIVE   = 1'b1,
    parameter bit AUTO_RESTART = 1'b1,
    localparam int NWORDS = (IMAGE_BITS + WORD_W - 1) / WORD_W,
    localparam int AW     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_in,
    output logic              oe_pull_low,
    input  logic              ncs_in,
    input  logic              dclk_in,
    output logic              dclk_out,
    output logic              dclk_oe,
    output logic              data_out,
    output logic              data_oe,
    output logic              ncasc_out,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_rdata
);

    localparam int OFFW = $clog2(WORD_W);
    localparam int T1   = (POR_CYC > ERR_HOLD) ? POR_CYC : ERR_HOLD;
    localparam int T2   = (TAIL_BITS > DONE_WIN) ? TAIL_BITS : DONE_WIN;
    localparam int TMAX = (T1 > T2) ? T1 : T2;
    localparam int TW   = $clog2(TMAX + 1);

    cfg_state_e      state, nxt;
    logic            is_master;
    logic [TW-1:0]   tmr;
    logic            tick, step, last_bit, clr_cnt, run_clk;
    logic            gen_dclk, period_end, din_rise;
    logic [OFFW-1:0] off_q;

    cfg_clk_gen #(.DIV(DCLK_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run_clk),
        .dclk(gen_dclk), .period_end(period_end)
    );

    cfg_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .pin(dclk_in), .rise(din_rise)
    );

    cfg_bit_counter #(.WORD_W(WORD_W), .IMAGE_BITS(IMAGE_BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(clr_cnt), .step(step),
        .mem_addr(mem_addr), .off_q(off_q), .last(last_bit)
    );

    assign step    = (state == ST_SEND) && (is_master ? period_end : din_rise);
    assign clr_cnt = (state == ST_POR) || (state == ST_HOLD);
    assign run_clk = is_master && (state inside {ST_SEND, ST_CASCADE, ST_WINDOW});
    assign tick    = (state inside {ST_POR, ST_ERROR}) ||
                     ((state inside {ST_CASCADE, ST_WINDOW}) && period_end);

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_POR:     if (tmr == TW'(POR_CYC - 1)) nxt = ST_HOLD;
            ST_HOLD:    if (oe_in) nxt = ncs_in ? ST_STANDBY : ST_SEND;
            ST_STANDBY: if (!ncs_in) nxt = ST_SEND;
            ST_SEND: begin
                if (ncs_in)
                    nxt = ST_ERROR;
                else if (step && last_bit)
                    nxt = (is_master && TAIL_BITS == 0) ? ST_WINDOW : ST_CASCADE;
            end
            ST_CASCADE: begin
                if (is_master) begin
                    if (ncs_in)
                        nxt = ST_ERROR;
                    else if (period_end && tmr == TW'(TAIL_BITS - 1))
                        nxt = ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (ncs_in)
                    nxt = ST_IDLE;
                else if (period_end && tmr == TW'(DONE_WIN - 1))
                    nxt = ST_ERROR;
            end
            ST_IDLE:    nxt = ST_IDLE;
            ST_ERROR:   if (AUTO_RESTART && tmr == TW'(ERR_HOLD - 1)) nxt = ST_HOLD;
            default:    nxt = ST_HOLD;
        endcase
        // An external low on OE resets every running state.
        if (!oe_in && !(state inside {ST_POR, ST_ERROR, ST_HOLD}))
            nxt = ST_HOLD;
    end

    // State register, phase timer and role
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_POR;
            tmr       <= '0;
            is_master <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state)
                tmr <= '0;
            else if (tick && tmr != '1)
                tmr <= tmr + TW'(1);
            if (state == ST_HOLD && oe_in)
                is_master <= !ncs_in;
        end
    end

    // Outputs
    always_comb begin
        oe_pull_low = (state == ST_POR) || (state == ST_ERROR);
        dclk_oe     = is_master && (state inside {ST_SEND, ST_CASCADE, ST_WINDOW, ST_IDLE});
        dclk_out    = gen_dclk;
        data_oe     = (state == ST_SEND) || ((state == ST_IDLE) && IDLE_DRIVE);
        data_out    = (state == ST_IDLE) ? 1'b1 : mem_rdata[off_q];
        ncasc_out   = !(state inside {ST_CASCADE, ST_WINDOW, ST_IDLE});
    end

endmodule

// File: rtl/cfg_stream_ctrl_chk.sv
module cfg_stream_ctrl_chk
    import cfg_stream_pkg::*;
#(
    parameter bit IDLE_DRIVE = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input cfg_state_e state,
    input logic       oe_in,
    input logic       ncs_in,
    input logic       oe_pull_low,
    input logic       dclk_oe,
    input logic       dclk_out,
    input logic       data_oe,
    input logic       data_out,
    input logic       ncasc_out
);

    p_oe_low_tristate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_in && $past(!oe_in)) |-> (!data_oe && ncasc_out));

    p_release_to_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_pull_low) |-> (state == ST_HOLD));

    p_standby_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STANDBY) |-> (!dclk_oe && !data_oe));

    p_handoff_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ncasc_out && state != ST_IDLE) |-> !data_oe);

    p_early_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && ncs_in && oe_in) |=> oe_pull_low);

    p_done_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && ncs_in && oe_in) |=> (state == ST_IDLE));

    p_idle_levels_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (dclk_oe && !dclk_out && data_oe == IDLE_DRIVE && data_out));

endmodule

bind cfg_stream_ctrl cfg_stream_ctrl_chk #(.IDLE_DRIVE(IDLE_DRIVE)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .oe_in(oe_in), .ncs_in(ncs_in),
    .oe_pull_low(oe_pull_low), .dclk_oe(dclk_oe), .dclk_out(dclk_out),
    .data_oe(data_oe), .data_out(data_out), .ncasc_out(ncasc_out)
);

// File: tb/cfg_stream_ctrl_test.sv
`timescale 1ns/1ps
module cfg_stream_ctrl_test;

    localparam int W = 8, N = 40, DIV = 8, TAIL = 24, WIN = 16, POR = 20, EHOLD = 6;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pull = 1'b0;
    logic ncs = 1'b1;
    logic dclk_in = 1'b0;
    logic oe_pull_low, dclk_out, dclk_oe, data_out, data_oe, ncasc_out;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_rdata = '0;
    wire  oe_line = !(oe_pull_low || ext_pull);

    int total = 0, bad = 0;
    int mbit = 0, rise_cnt = 0;
    logic prev_oe = 1'b1, prev_dclk = 1'b0;

    always #5 clk = ~clk;

    cfg_stream_ctrl #(
        .WORD_W(W), .IMAGE_BITS(N), .DCLK_DIV(DIV), .TAIL_BITS(TAIL),
        .DONE_WIN(WIN), .POR_CYC(POR), .ERR_HOLD(EHOLD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .oe_in(oe_line), .oe_pull_low(oe_pull_low),
        .ncs_in(ncs), .dclk_in(dclk_in), .dclk_out(dclk_out), .dclk_oe(dclk_oe),
        .data_out(data_out), .data_oe(data_oe), .ncasc_out(ncasc_out),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [W-1:0] word_of(int a);
        return W'((a * 91) ^ 166);
    endfunction

    function automatic logic exp_bit(int k);
        logic [W-1:0] w;
        w = word_of(k / W);
        return w[k % W];
    endfunction

    // Synchronous memory model: one cycle of latency.
    always @(posedge clk) mem_rdata <= word_of(int'(mem_addr));

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Reference view of the target: sample at every serial clock rise, check every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!oe_line && !prev_oe)
                chk(!data_oe && ncasc_out, "R1 oe low", {data_oe, ncasc_out}, 1);
            if (dclk_out && !prev_dclk && dclk_oe) begin
                rise_cnt++;
                if (data_oe) begin
                    chk(data_out == exp_bit(mbit), "R4 master bit", data_out, exp_bit(mbit));
                    mbit++;
                end
            end
        end
        prev_oe   = oe_line;
        prev_dclk = dclk_out;
    end

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnt, r0;
        wait_neg(3);
        chk(oe_pull_low && !data_oe && !dclk_oe && ncasc_out, "R2 reset state",
            {oe_pull_low, data_oe, dclk_oe, ncasc_out}, 4'b1001);
        rst_n = 1'b1;
        cnt = 0;
        while (oe_pull_low && cnt < 1000) begin cnt++; @(negedge clk); end
        chk(cnt == POR, "R2 power-on length", cnt, POR);

        // Slave role: select high at release.
        wait_neg(2);
        chk(!dclk_oe && !data_oe && ncasc_out, "R3 standby quiet", {dclk_oe, data_oe}, 0);
        for (int i = 0; i < 3; i++) begin
            dclk_in = 1'b1; wait_neg(6); dclk_in = 1'b0; wait_neg(6);
        end
        chk(!data_oe, "R3 clock ignored in standby", data_oe, 0);
        ncs = 1'b0;
        for (int k = 0; k < N; k++) begin
            wait_neg(4);
            chk(data_oe && data_out == exp_bit(k), "R3 R4 slave bit", data_out, exp_bit(k));
            chk(k == N - 1 || ncasc_out, "R5 no early handoff", ncasc_out, 1);
            dclk_in = 1'b1; wait_neg(8); dclk_in = 1'b0;
        end
        wait_neg(6);
        chk(!ncasc_out && !data_oe, "R5 slave handoff", {ncasc_out, data_oe}, 0);

        // External OE pulse resets and the block comes back as master.
        ext_pull = 1'b1;
        wait_neg(3);
        chk(!data_oe && ncasc_out && !dclk_oe, "R1 external reset", {data_oe, ncasc_out}, 1);
        mbit = 0; rise_cnt = 0;
        ext_pull = 1'b0;
        wait_neg(3);
        chk(dclk_oe, "R3 master drives clock", dclk_oe, 1);
        while (mbit < N) @(negedge clk);
        wait_neg(1);
        while (ncasc_out) @(negedge clk);
        chk(mbit == N && !data_oe, "R5 master handoff", mbit, N);
        r0 = rise_cnt;
        while (!oe_pull_low) @(negedge clk);
        chk(rise_cnt - r0 == TAIL + WIN, "R6 R8 clocks before timeout", rise_cnt - r0, TAIL + WIN);

        // Auto-restart after the timeout.
        mbit = 0;
        cnt = 0;
        while (oe_pull_low && cnt < 1000) begin cnt++; @(negedge clk); end
        chk(cnt == EHOLD, "R10 error pulse length", cnt, EHOLD);
        while (mbit < N) @(negedge clk);
        chk(mbit == N, "R10 restart from bit 0", mbit, N);
        while (ncasc_out) @(negedge clk);
        r0 = rise_cnt;
        while (rise_cnt < r0 + TAIL + 3) @(negedge clk);
        ncs = 1'b1;
        wait_neg(3);
        chk(dclk_oe && !dclk_out && data_oe && data_out, "R9 idle levels",
            {dclk_oe, dclk_out, data_oe, data_out}, 4'b1011);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (oe_pull_low || dclk_out) cnt++;
        end
        chk(cnt == 0, "R9 idle stays quiet", cnt, 0);

        // Early done flag while sending.
        ext_pull = 1'b1; ncs = 1'b0;
        wait_neg(3);
        mbit = 0;
        ext_pull = 1'b0;
        while (mbit < 10) @(negedge clk);
        ncs = 1'b1;
        @(negedge clk);
        chk(oe_pull_low && mbit < N, "R7 early done error", oe_pull_low, 1);
        while (oe_pull_low) @(negedge clk);
        wait_neg(3);
        chk(!dclk_oe && !data_oe, "R3 slave after restart", {dclk_oe, data_oe}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule